// File: doc/BRIEF.md
# Long-Silence Auto-Mute Detector

This block watches the decoded audio samples of a multi-channel serial input and raises a mute flag once the input has stayed all-zero for roughly half a second. It sees one sample word per channel together with a strobe that marks each new frame. A two-bit rate setting picks the timeout, which is counted in frames so that the same half second holds at each supported sample rate.

A single non-zero bit in any channel clears the flag and restarts the count on the same frame. Two separate register controls can switch the detector off. The first is an auto-mute enable that is active low, so 0 enables it. The second is a test-register disable bit, where 1 disables it. The detector is enabled after reset. The flag is meant to drive the muting of the analog output stage, which sits outside this block.

Top module: `silence_mute`

## Requirements
- R1: While reset is held and in the first cycle after its release, `mute_o` is 0.
- R2: With rate code 0 (48 kHz, default limit 24000 frames), `mute_o` stays 0 through LIM_48K-1 consecutive all-zero frames and becomes 1 on the clock edge that registers the LIM_48K-th one.
- R3: The rate code selects the frame limit: 0 selects LIM_48K, 1 selects LIM_44K1 (default 22050), 2 selects LIM_32K (default 16000) and 3 selects LIM_96K (default 48000). Each limit follows the same onset timing as R2.
- R4: A strobed frame with any non-zero sample bit clears `mute_o` on the edge that registers it. The count then starts again from zero, so a further full limit of zero frames is needed to mute.
- R5: A frame is zero only when every channel word is zero. A single set bit in any one channel, including the highest channel slot of `sample_i` (channel k occupies bits k*W+W-1 down to k*W), counts as non-zero.
- R6: Cycles with `frame_stb_i` low neither advance nor clear the count, and the sample value on those cycles is ignored.
- R7: While `amute_dis_i` is 1, `mute_o` is 0 from the next edge on and the count is cleared. After the input returns to 0, a full limit of zero frames is needed again.
- R8: While `zdet_off_i` is 1, the detector behaves exactly as in R7.
- R9: Once muted, `mute_o` stays 1 for any number of further zero frames. The count saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb_i | input | 1 | One-cycle strobe marking a new frame of samples |
| sample_i | input | NCH*W | Sample words of all channels, channel 0 in the low bits |
| rate_i | input | 2 | Sample-rate code selecting the timeout (see R3) |
| amute_dis_i | input | 1 | Auto-mute enable, active low: 1 disables the detector |
| zdet_off_i | input | 1 | Test-register disable: 1 disables the detector |
| mute_o | output | 1 | Long-silence mute flag |

## Verification
The hardest state to reach from the ports is the exact onset edge at each of the four limits. The bench reaches it by overriding the limits with small distinct values, so that every rate can be driven to one frame short of its limit and then over it. The edge is checked on both sides. A second hard case is a disable arriving while the flag is set. The bench first mutes the block, then pulses each disable control and replays a full run of zero frames to show that the count really restarted rather than resuming.

// File: rtl/silence_mute_pkg.sv
package silence_mute_pkg;

   typedef enum logic [1:0] {
      RATE_48K  = 2'd0,
      RATE_44K1 = 2'd1,
      RATE_32K  = 2'd2,
      RATE_96K  = 2'd3
   } rate_e;

   function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/silence_zero_det.sv
module silence_zero_det #(
   parameter int NCH = 6,
   parameter int W   = 24
) (
   input  logic [NCH*W-1:0] sample_i,
   output logic             all_zero_o
);
   logic [NCH-1:0] ch_busy;

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      assign ch_busy[k] = |sample_i[k*W +: W];
   end

   assign all_zero_o = ~|ch_busy;
endmodule

// File: rtl/silence_limit_sel.sv
module silence_limit_sel
   import silence_mute_pkg::*;
#(
   parameter int unsigned LIM_48K  = 24000,
   parameter int unsigned LIM_44K1 = 22050,
   parameter int unsigned LIM_32K  = 16000,
   parameter int unsigned LIM_96K  = 48000,
   parameter int          CNT_W    = 16
) (
   input  logic [1:0]       rate_i,
   output logic [CNT_W-1:0] limit_o
);
   always_comb begin
      unique case (rate_e'(rate_i))
         RATE_48K:  limit_o = CNT_W'(LIM_48K);
         RATE_44K1: limit_o = CNT_W'(LIM_44K1);
         RATE_32K:  limit_o = CNT_W'(LIM_32K);
         RATE_96K:  limit_o = CNT_W'(LIM_96K);
         default:   limit_o = CNT_W'(LIM_48K);
      endcase
   end
endmodule

// File: rtl/silence_run_cnt.sv
module silence_run_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable_i,
   input  logic             stb_i,
   input  logic             zero_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             mute_o
);
   logic [CNT_W-1:0] run_q;
   logic [CNT_W:0]   run_inc;
   logic             mute_q;

   assign run_inc = {1'b0, run_q} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         mute_q <= 1'b0;
      end else if (!enable_i) begin
         run_q  <= '0;
         mute_q <= 1'b0;
      end else if (stb_i) begin
         if (!zero_i) begin
            run_q  <= '0;
            mute_q <= 1'b0;
         end else if (run_inc >= {1'b0, limit_i}) begin
            run_q  <= limit_i;
            mute_q <= 1'b1;
         end else begin
            run_q  <= run_inc[CNT_W-1:0];
         end
      end
   end

   assign mute_o = mute_q;
endmodule

// File: rtl/silence_mute.sv
module silence_mute
   import silence_mute_pkg::*;
#(
   parameter int          NCH      = 6,
   parameter int          W        = 24,
   parameter int unsigned LIM_48K  = 24000,
   parameter int unsigned LIM_44K1 = 22050,
   parameter int unsigned LIM_32K  = 16000,
   parameter int unsigned LIM_96K  = 48000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_stb_i,
   input  logic [NCH*W-1:0] sample_i,
   input  logic [1:0]       rate_i,
   input  logic             amute_dis_i,
   input  logic             zdet_off_i,
   output logic             mute_o
);
   localparam int unsigned LIM_MAX = max4(LIM_48K, LIM_44K1, LIM_32K, LIM_96K);
   localparam int          CNT_W   = $clog2(LIM_MAX + 1);

   if (NCH < 1 || W < 1) begin : g_bad_shape
      initial $fatal(1, "silence_mute: NCH and W must be at least 1");
   end
   if (LIM_48K < 1 || LIM_44K1 < 1 || LIM_32K < 1 || LIM_96K < 1) begin : g_bad_limit
      initial $fatal(1, "silence_mute: every frame limit must be at least 1");
   end

   logic             all_zero;
   logic [CNT_W-1:0] limit;
   logic             det_en;

   assign det_en = !amute_dis_i && !zdet_off_i;

   silence_zero_det #(.NCH(NCH), .W(W)) u_zero (
      .sample_i   (sample_i),
      .all_zero_o (all_zero)
   );

   silence_limit_sel #(
      .LIM_48K(LIM_48K), .LIM_44K1(LIM_44K1),
      .LIM_32K(LIM_32K), .LIM_96K(LIM_96K), .CNT_W(CNT_W)
   ) u_limit (
      .rate_i  (rate_i),
      .limit_o (limit)
   );

   silence_run_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (det_en),
      .stb_i    (frame_stb_i),
      .zero_i   (all_zero),
      .limit_i  (limit),
      .mute_o   (mute_o)
   );
endmodule

// File: rtl/silence_mute_chk.sv
module silence_mute_chk #(
   parameter int NCH = 6,
   parameter int W   = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_stb_i,
   input logic [NCH*W-1:0] sample_i,
   input logic             amute_dis_i,
   input logic             zdet_off_i,
   input logic             mute_o
);
   logic frame_nz;
   logic off;
   assign frame_nz = (sample_i != '0);
   assign off      = amute_dis_i || zdet_off_i;

   a_r4_nonzero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb_i && frame_nz) |=> !mute_o);

   a_r7_disable_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
      off |=> !mute_o);

   a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_stb_i && !off) |=> $stable(mute_o));

   a_r2_rise_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mute_o) |-> $past(frame_stb_i && !frame_nz && !off));

   a_r9_stays_muted: assert property (@(posedge clk) disable iff (!rst_n)
      (mute_o && frame_stb_i && !frame_nz && !off) |=> mute_o);
endmodule

bind silence_mute silence_mute_chk #(.NCH(NCH), .W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_stb_i (frame_stb_i),
   .sample_i    (sample_i),
   .amute_dis_i (amute_dis_i),
   .zdet_off_i  (zdet_off_i),
   .mute_o      (mute_o)
);

// File: tb/tb_silence_mute.sv
module tb_silence_mute;
   localparam int NCH = 2;
   localparam int W   = 24;
   localparam int L48 = 20;
   localparam int L44 = 18;
   localparam int L32 = 13;
   localparam int L96 = 40;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             stb;
   logic [NCH*W-1:0] smp;
   logic [1:0]       rate;
   logic             amute_dis;
   logic             zdet_off;
   logic             mute;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   silence_mute #(.NCH(NCH), .W(W), .LIM_48K(L48), .LIM_44K1(L44),
                  .LIM_32K(L32), .LIM_96K(L96)) dut (
      .clk(clk), .rst_n(rst_n), .frame_stb_i(stb), .sample_i(smp),
      .rate_i(rate), .amute_dis_i(amute_dis), .zdet_off_i(zdet_off), .mute_o(mute)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input logic exp);
      checks++;
      if (mute !== exp) begin
         errors++;
         $display("FAIL %s: mute actual=%b expected=%b", req, mute, exp);
      end
   endtask

   task automatic frame(input logic [NCH*W-1:0] d);
      stb = 1'b1; smp = d;
      @(negedge clk);
      stb = 1'b0; smp = '0;
   endtask

   task automatic zeros(input int n);
      for (int i = 0; i < n; i++) frame('0);
   endtask

   task automatic onset(input string req, input int lim);
      zeros(lim - 1);
      check(req, 1'b0);
      zeros(1);
      check(req, 1'b1);
   endtask

   task automatic t_reset;
      rst_n = 1'b0; stb = 1'b0; smp = '0; rate = 2'd0; amute_dis = 1'b0; zdet_off = 1'b0;
      repeat (3) @(negedge clk);
      check("R1", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 1'b0);
   endtask

   task automatic t_r2_onset;
      onset("R2", L48);
   endtask

   task automatic t_r9_saturate;
      zeros(3 * L48);
      check("R9", 1'b1);
   endtask

   task automatic t_r4_clear;
      frame(48'h000000_800000);
      check("R4", 1'b0);
      onset("R4", L48);
   endtask

   task automatic t_r5_channel;
      frame(48'h000001_000000);
      check("R5", 1'b0);
      zeros(L48 - 1);
      check("R5", 1'b0);
      frame(48'h000000_000001);
      zeros(L48 - 1);
      check("R5", 1'b0);
   endtask

   task automatic t_r6_idle;
      frame(48'h000000_000001);
      zeros(10);
      smp = '1;
      repeat (5) @(negedge clk);
      smp = '0;
      check("R6", 1'b0);
      zeros(L48 - 11);
      check("R6", 1'b0);
      zeros(1);
      check("R6", 1'b1);
   endtask

   task automatic t_r3_rates;
      int lims [4] = '{L48, L44, L32, L96};
      for (int r = 0; r < 4; r++) begin
         frame(48'h000000_000010);
         rate = 2'(r);
         onset("R3", lims[r]);
      end
      rate = 2'd0;
   endtask

   task automatic t_disable(input string req, input logic use_test);
      frame(48'h000000_000002);
      zeros(L48);
      check(req, 1'b1);
      if (use_test) zdet_off = 1'b1; else amute_dis = 1'b1;
      @(negedge clk);
      check(req, 1'b0);
      zeros(2 * L48);
      check(req, 1'b0);
      zdet_off = 1'b0; amute_dis = 1'b0;
      onset(req, L48);
   endtask

   initial begin
      t_reset();
      t_r2_onset();
      t_r9_saturate();
      t_r4_clear();
      t_r5_channel();
      t_r6_idle();
      t_r3_rates();
      t_disable("R7", 1'b0);
      t_disable("R8", 1'b1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule